// File: doc/BRIEF.md
# Clear-To-Send Status Monitor

This block watches the active-low clear-to-send line of a serial port. The raw pin is asynchronous to the block clock, so it is first brought into the clock domain. Two results come from the synchronized line. The first is a level bit that is high while the far end allows sending, which is the logical inverse of the pin. The second is a sticky change flag that records every rising or falling transition of the line.

The change flag records transitions only while the tracking enable is high. Software clears the flag with a one-cycle clear strobe. If a new transition lands in the same cycle as the strobe, the transition wins and the flag stays set. The interrupt output is the change flag gated by an interrupt enable.

A build parameter can remove the feature. In that case the level bit, the change flag and the interrupt all read as constant 0.

Top module: `cts_status_monitor`

## Requirements
- R1: `cts_level_o` is the inverse of the synchronized pin. It reads 1 when `cts_n_pin_i` is low and 0 when the pin is high. It follows a pin change on the second rising clock edge after that change.
- R2: When tracking is enabled, any transition of the synchronized pin, rising or falling, sets `cts_change_o`. The flag is set on the third rising edge after the pin change.
- R3: A transition does not set `cts_change_o` if `cts_track_en_i` is 0 in the cycle the transition is detected. Raising the enable afterwards does not record earlier transitions.
- R4: `cts_change_o` stays at 1 until a cycle in which `chg_clear_i` is 1. It reads 0 on the edge after that cycle.
- R5: If a recorded transition and `chg_clear_i` fall in the same cycle, `cts_change_o` remains 1.
- R6: `cts_irq_o` equals `cts_change_o` AND `chg_irq_en_i`.
- R7: With parameter `FEATURE_ON` = 0, `cts_level_o`, `cts_change_o` and `cts_irq_o` are constant 0.
- R8: The synchronizer resets to the idle-high pin state. After reset, `cts_level_o` and `cts_change_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cts_n_pin_i | input | 1 | Raw active-low clear-to-send pin, asynchronous |
| cts_track_en_i | input | 1 | Enables recording of line transitions |
| chg_clear_i | input | 1 | One-cycle strobe that clears the change flag |
| chg_irq_en_i | input | 1 | Interrupt enable for the change flag |
| cts_level_o | output | 1 | Inverted synchronized pin level |
| cts_change_o | output | 1 | Sticky transition flag |
| cts_irq_o | output | 1 | Change flag gated by the interrupt enable |

## Verification
A pin change passes through two synchronizer flops, so the level bit is due two edges after the change. The edge detector and the flag register add one more edge, so the change flag is due on the third edge. The interrupt is combinational on the flag and its enable. The bench drives every input one time unit after a rising edge and samples one time unit after the edge it counts to. It reads the flag once after two edges to confirm it is still clear, and again after three edges to confirm it is set. The clear-versus-transition collision is forced by raising the strobe exactly in the cycle the transition is detected.

// File: rtl/cts_mon_pkg.sv
package cts_mon_pkg;
    // State of the edge detector: the previous synchronized pin value.
    typedef struct packed {
        logic prev;
    } edge_state_t;

    // State of the sticky change flag.
    typedef struct packed {
        logic flag;
    } flag_state_t;

    // Pin idles high (not clear to send).
    localparam logic PIN_IDLE = 1'b1;
endpackage

// File: rtl/cts_pin_sync.sv
module cts_pin_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cts_edge_det.sv
module cts_edge_det
    import cts_mon_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic toggle_o
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = line_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{prev: PIN_IDLE};
        else         st_q <= st_d;
    end

    assign toggle_o = line_i ^ st_q.prev;
endmodule

// File: rtl/cts_change_flag.sv
module cts_change_flag
    import cts_mon_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clear_i,
    output logic flag_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)        st_d.flag = 1'b1;  // a new transition beats the clear
        else if (clear_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{flag: 1'b0};
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/cts_status_monitor.sv
module cts_status_monitor
    import cts_mon_pkg::*;
#(
    parameter bit FEATURE_ON  = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cts_n_pin_i,
    input  logic cts_track_en_i,
    input  logic chg_clear_i,
    input  logic chg_irq_en_i,
    output logic cts_level_o,
    output logic cts_change_o,
    output logic cts_irq_o
);
    logic pin_sync_w;
    logic toggle_w;
    logic record_w;
    logic flag_w;

    generate
        if (FEATURE_ON) begin : g_on
            cts_pin_sync #(
                .STAGES (SYNC_STAGES),
                .RST_VAL(PIN_IDLE)
            ) sync_i (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .async_i(cts_n_pin_i),
                .sync_o (pin_sync_w)
            );

            cts_edge_det edge_i (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .line_i  (pin_sync_w),
                .toggle_o(toggle_w)
            );

            assign record_w = toggle_w & cts_track_en_i;

            cts_change_flag flag_i (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .set_i  (record_w),
                .clear_i(chg_clear_i),
                .flag_o (flag_w)
            );

            assign cts_level_o  = ~pin_sync_w;
            assign cts_change_o = flag_w;
            assign cts_irq_o    = flag_w & chg_irq_en_i;
        end else begin : g_off
            assign pin_sync_w   = PIN_IDLE;
            assign toggle_w     = 1'b0;
            assign record_w     = 1'b0;
            assign flag_w       = 1'b0;
            assign cts_level_o  = 1'b0;
            assign cts_change_o = 1'b0;
            assign cts_irq_o    = 1'b0;
        end
    endgenerate
endmodule

module cts_status_monitor_chk #(
    parameter bit FEATURE_ON = 1'b1
) (
    input logic clk_i,
    input logic rst_ni,
    input logic cts_track_en_i,
    input logic chg_clear_i,
    input logic chg_irq_en_i,
    input logic cts_level_o,
    input logic cts_change_o,
    input logic cts_irq_o,
    input logic toggle_w
);
    AST_SET_ON_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (toggle_w && cts_track_en_i) |=> cts_change_o); // R2
    AST_NO_SET_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cts_change_o && !cts_track_en_i) |=> !cts_change_o); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cts_change_o && !chg_clear_i) |=> cts_change_o); // R4
    AST_CLEAR_WINS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chg_clear_i && !(toggle_w && cts_track_en_i)) |=> !cts_change_o); // R4
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chg_clear_i && toggle_w && cts_track_en_i) |=> cts_change_o); // R5
    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cts_irq_o == (cts_change_o && chg_irq_en_i)); // R6
    AST_ABSENT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !FEATURE_ON |-> !(cts_level_o || cts_change_o || cts_irq_o)); // R7
endmodule

bind cts_status_monitor cts_status_monitor_chk #(.FEATURE_ON(FEATURE_ON)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cts_track_en_i(cts_track_en_i),
    .chg_clear_i   (chg_clear_i),
    .chg_irq_en_i  (chg_irq_en_i),
    .cts_level_o   (cts_level_o),
    .cts_change_o  (cts_change_o),
    .cts_irq_o     (cts_irq_o),
    .toggle_w      (toggle_w)
);

// File: tb/cts_status_monitor_tb.sv
`timescale 1ns/1ps
module cts_status_monitor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b1;
    logic en = 1'b0;
    logic clr = 1'b0;
    logic ien = 1'b0;
    logic lvl, chg, irq;
    logic lvl_x, chg_x, irq_x;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    cts_status_monitor #(.FEATURE_ON(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cts_n_pin_i(pin), .cts_track_en_i(en),
        .chg_clear_i(clr), .chg_irq_en_i(ien),
        .cts_level_o(lvl), .cts_change_o(chg), .cts_irq_o(irq));

    cts_status_monitor #(.FEATURE_ON(1'b0)) dut_off_i (
        .clk_i(clk), .rst_ni(rst_n), .cts_n_pin_i(pin), .cts_track_en_i(en),
        .chg_clear_i(clr), .chg_irq_en_i(ien),
        .cts_level_o(lvl_x), .cts_change_o(chg_x), .cts_irq_o(irq_x));

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_absent();
        check("R7 level", lvl_x, 1'b0);
        check("R7 change", chg_x, 1'b0);
        check("R7 irq", irq_x, 1'b0);
    endtask

    task automatic clear_flag();
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        check("R4 cleared", chg, 1'b0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R8 level", lvl, 1'b0);
        check("R8 change", chg, 1'b0);
        check_absent();
        step(4);
        check("R8 no spurious flag", chg, 1'b0);

        // Sweep over enable, irq enable and both edge directions.
        for (int e = 0; e < 2; e++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int d = 0; d < 2; d++) begin
                    en  = e[0];
                    ien = ie[0];
                    pin = ~pin;
                    step(1);
                    check("R1 level not yet", lvl, pin);  // old level
                    step(1);
                    check("R1 level", lvl, ~pin);
                    check("R2 flag not yet", chg, 1'b0);
                    step(1);
                    check(e ? "R2 flag set" : "R3 flag blocked", chg, e[0]);
                    check("R6 irq", irq, e[0] & ie[0]);
                    check_absent();
                    step(3);
                    check("R4 sticky", chg, e[0]);
                    ien = 1'b1;
                    #1 check("R6 irq follows enable", irq, e[0]);
                    ien = 1'b0;
                    #1 check("R6 irq masked", irq, 1'b0);
                    clear_flag();
                end
            end
        end

        // Transition with tracking off, then enable later: nothing recorded.
        en  = 1'b0;
        pin = ~pin;
        step(4);
        en = 1'b1;
        step(4);
        check("R3 late enable", chg, 1'b0);

        // Enable dropped only in the detect cycle blocks recording.
        pin = ~pin;
        step(2);
        en = 1'b0;
        step(1);
        check("R3 enable at detect", chg, 1'b0);
        en = 1'b1;

        // Collision: clear strobe in the detect cycle, flag already set.
        pin = ~pin;
        step(3);
        check("R2 set before collision", chg, 1'b1);
        pin = ~pin;
        step(2);
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        check("R5 set beats clear (flag set)", chg, 1'b1);
        clear_flag();

        // Collision with flag clear beforehand.
        pin = ~pin;
        step(2);
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        check("R5 set beats clear (flag clear)", chg, 1'b1);
        step(1);
        clear_flag();
        step(2);
        check("R4 stays clear", chg, 1'b0);
        check_absent();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule